// File: doc/BRIEF.md
# Precise Exception Control Unit

This block is the trap controller of a five-stage in-order pipeline. Two stages can report a fault. Decode reports an instruction whose opcode is reserved or undefined. Execute reports signed overflow on an add or subtract. Each report comes with the program counter of the faulting instruction and a flag. The flag says whether that instruction sits in the delay slot of a branch.

In the cycle a report arrives, the unit picks the oldest faulting instruction. It asserts kill signals for that instruction and for every younger one, so none of them changes architectural state. It also forces the next fetch address to the fixed handler entry 0x80000180. On the clock edge that closes that cycle, it loads the two coprocessor registers:
- the exception program counter (EPC);
- the cause word, which holds the fault code and a delay-slot flag.

A combinational read port serves the move-from-coprocessor instruction. An even register index returns the EPC and an odd index returns the cause word. There is no privilege mode, no status register and no masking: every report is taken.

Top module: `precise_trap_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, both coprocessor registers are cleared to zero. After reset, reads at even and at odd indices return 0.
- R2: In a cycle with no fault report:
  - `kill_if`, `kill_id`, `kill_ex` and `redirect` are all 0;
  - the EPC and the cause word keep their values.
- R3: In any cycle with a fault report, `redirect` is 1 and `redirect_pc` equals 0x80000180.
- R4: A fault reported by execute asserts `kill_if`, `kill_id` and `kill_ex` in the same cycle. At the next edge, the cause word gets code 12 in bits 6:2, so its low byte is 0x30.
- R5: A fault reported by decode alone asserts `kill_if` and `kill_id` with `kill_ex` low. At the next edge, the cause word gets code 10 in bits 6:2 (low byte 0x28).
- R6: When decode and execute report in the same cycle, the execute report wins. Its code, its program counter and its delay-slot flag are stored, and the decode report is dropped.
- R7: For a winning report outside a delay slot, the EPC gets its program counter and cause bit 31 is 0. For one inside a delay slot, the EPC gets that counter minus 4 (the branch address) and cause bit 31 is 1. Every cause bit other than 31 and 6:2 is 0.
- R8: `cp0_rdata` is combinational in `cp0_rd`. Bit 0 of the index selects the register: 0 gives the EPC, 1 gives the cause word.
- R9: The registers are written on the edge that ends the report cycle. A read in the very next cycle already returns the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_ovf | input | 1 | Execute stage reports signed overflow |
| ex_pc | input | 32 | Program counter of the execute-stage instruction |
| ex_in_slot | input | 1 | Execute-stage instruction is in a branch delay slot |
| id_bad_op | input | 1 | Decode stage reports a reserved opcode |
| id_pc | input | 32 | Program counter of the decode-stage instruction |
| id_in_slot | input | 1 | Decode-stage instruction is in a branch delay slot |
| kill_if | output | 1 | Cancel the instruction in fetch |
| kill_id | output | 1 | Cancel the instruction in decode |
| kill_ex | output | 1 | Cancel the instruction in execute |
| redirect | output | 1 | Force the next fetch address |
| redirect_pc | output | 32 | Forced fetch address (handler entry) |
| cp0_rd | input | 5 | Coprocessor register index of a read |
| cp0_rdata | output | 32 | Read data |

## Verification
The kill signals and the redirect are combinational in the fault reports. The bench therefore samples them in the same cycle the report is driven, two time units after the falling edge and well before the next rising edge. The EPC and cause updates appear one edge later. The bench clears the reports at the following falling edge and then reads the read port at both an even and an odd index within that next cycle, which also covers the no-stall read after a trap. A separate check confirms that a quiet cycle leaves both registers unchanged.

// File: rtl/trap_pkg.sv
// Package: shared constants and request type of the trap controller.
// Assumes a 32-bit address space and the cause layout used by the unit.
package trap_pkg;
    localparam int XLEN         = 32;
    localparam int CODE_W       = 5;
    localparam int CODE_LSB     = 2;
    localparam int BD_BIT       = 31;
    localparam int RD_W         = 5;
    localparam logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180;
    localparam logic [XLEN-1:0] SLOT_BACK  = 32'd4;
    localparam logic [CODE_W-1:0] CODE_OVF = 5'd12;
    localparam logic [CODE_W-1:0] CODE_RSV = 5'd10;

    typedef struct packed {
        logic              valid;
        logic [XLEN-1:0]   pc;
        logic              slot;
        logic [CODE_W-1:0] code;
    } trap_req_t;
endpackage

// File: rtl/trap_pick.sv
// Module: trap_pick
// Picks the oldest valid request. Index 0 is the oldest (furthest down
// the pipeline). Assumes requests are stable for the whole cycle.
module trap_pick
    import trap_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  trap_req_t             src [NUM_SRC],
    output logic                  take,
    output trap_req_t             win,
    output logic [NUM_SRC-1:0]    grant
);
    // Priority select: the lowest index wins, younger ones are dropped.
    always_comb begin
        win   = '0;
        grant = '0;
        take  = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (src[i].valid) begin
                win   = src[i];
                grant = '0;
                grant[i] = 1'b1;
                take  = 1'b1;
            end
        end
    end

    // At most one grant, and a grant exists exactly when a request is taken.
    always_comb begin
        assert_one_grant_R6: assert ($onehot0(grant) && (take == (grant != '0)))
            else $error("grant not one-hot");
    end
endmodule

// File: rtl/trap_regs.sv
// Module: trap_regs
// Holds EPC and the cause word. On a taken trap it stores the faulting
// program counter (minus 4 in a delay slot) and the code with the slot flag.
// Assumes a synchronous active-low reset.
module trap_regs
    import trap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  trap_req_t       win,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] cause_q
);
    logic [XLEN-1:0] epc_d;
    logic [XLEN-1:0] cause_d;

    // Build the next EPC and the cause word from the winning request.
    always_comb begin
        epc_d   = win.slot ? (win.pc - SLOT_BACK) : win.pc;
        cause_d = '0;
        cause_d[BD_BIT] = win.slot;
        cause_d[CODE_LSB +: CODE_W] = win.code;
    end

    // Register update: clear on reset, load on a taken trap, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (take) begin
            epc_q   <= epc_d;
            cause_q <= cause_d;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(epc_q) && $stable(cause_q)))
        else $error("registers changed without a trap");

    assert_bd_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win.slot) |=> (cause_q[BD_BIT] && epc_q == $past(win.pc) - SLOT_BACK))
        else $error("delay slot trap recorded wrongly");
endmodule

// File: rtl/cp0_read.sv
// Module: cp0_read
// Combinational read port. The index parity picks the register:
// even gives EPC, odd gives the cause word.
module cp0_read
    import trap_pkg::*;
(
    input  logic [RD_W-1:0] rd,
    input  logic [XLEN-1:0] epc_q,
    input  logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] rdata
);
    logic unused_rd_hi;

    // Read multiplexer; only bit 0 of the index matters.
    always_comb begin
        unused_rd_hi = |rd[RD_W-1:1];
        rdata        = rd[0] ? cause_q : epc_q;
    end
endmodule

// File: rtl/precise_trap_unit.sv
// Module: precise_trap_unit
// Top of the trap controller. Execute (overflow) is older than decode
// (reserved opcode). Kills and redirect are combinational; EPC and the cause
// word load on the edge that ends the trap cycle.
// Assumes the pipeline honours the kills in the same cycle.
module precise_trap_unit
    import trap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_ovf,
    input  logic [31:0]     ex_pc,
    input  logic            ex_in_slot,
    input  logic            id_bad_op,
    input  logic [31:0]     id_pc,
    input  logic            id_in_slot,
    output logic            kill_if,
    output logic            kill_id,
    output logic            kill_ex,
    output logic            redirect,
    output logic [31:0]     redirect_pc,
    input  logic [4:0]      cp0_rd,
    output logic [31:0]     cp0_rdata
);
    localparam int NUM_SRC = 2;
    localparam int SRC_EX  = 0;
    localparam int SRC_ID  = 1;

    trap_req_t            reqs [NUM_SRC];
    trap_req_t            win;
    logic                 take;
    logic [NUM_SRC-1:0]   grant;
    logic [XLEN-1:0]      epc_q;
    logic [XLEN-1:0]      cause_q;

    // Gather the stage reports into requests, oldest first.
    always_comb begin
        reqs[SRC_EX] = '{valid: ex_ovf,    pc: ex_pc, slot: ex_in_slot, code: CODE_OVF};
        reqs[SRC_ID] = '{valid: id_bad_op, pc: id_pc, slot: id_in_slot, code: CODE_RSV};
    end

    trap_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .src   (reqs),
        .take  (take),
        .win   (win),
        .grant (grant)
    );

    trap_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .win     (win),
        .epc_q   (epc_q),
        .cause_q (cause_q)
    );

    cp0_read u_read (
        .rd      (cp0_rd),
        .epc_q   (epc_q),
        .cause_q (cause_q),
        .rdata   (cp0_rdata)
    );

    // Flush and redirect: the winner and every younger stage are cancelled.
    always_comb begin
        kill_if     = take;
        kill_id     = take;
        kill_ex     = grant[SRC_EX];
        redirect    = take;
        redirect_pc = HANDLER_PC;
    end

    assert_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ovf || id_bad_op) |-> (redirect && redirect_pc == HANDLER_PC))
        else $error("no redirect on a trap");

    assert_kill_ex_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ex_ovf |-> (kill_if && kill_id && kill_ex))
        else $error("overflow did not kill all stages");

    assert_code_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ex_ovf |=> (cause_q[CODE_LSB +: CODE_W] == CODE_OVF))
        else $error("overflow code not stored");

    assert_decode_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_bad_op && !ex_ovf) |-> (kill_if && kill_id && !kill_ex))
        else $error("decode trap killed execute");

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_ovf || id_bad_op) |-> !(kill_if || kill_id || kill_ex || redirect))
        else $error("kill without a trap");
endmodule

// File: tb/test_precise_trap_unit.sv
module test_precise_trap_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // Vector layout: ex_ovf, ex_pc, ex_slot, id_bad, id_pc, id_slot,
    // expected kill {ex,id,if}, expected redirect, expected EPC, expected cause.
    typedef struct packed {
        logic        exr;
        logic [31:0] expc;
        logic        exs;
        logic        idr;
        logic [31:0] idpc;
        logic        ids;
        logic [2:0]  kill;
        logic        redir;
        logic [31:0] epc;
        logic [31:0] cause;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 32'h0040_0010, 1'b0, 1'b0, 32'h0,          1'b0, 3'b111, 1'b1, 32'h0040_0010, 32'h0000_0030},
        '{1'b0, 32'h0,         1'b0, 1'b1, 32'h0040_0104, 1'b1, 3'b011, 1'b1, 32'h0040_0100, 32'h8000_0028},
        '{1'b1, 32'h0040_0200, 1'b1, 1'b1, 32'h0040_0204, 1'b0, 3'b111, 1'b1, 32'h0040_01FC, 32'h8000_0030},
        '{1'b0, 32'h1234_5678, 1'b1, 1'b0, 32'h0BAD_0000, 1'b1, 3'b000, 1'b0, 32'h0040_01FC, 32'h8000_0030},
        '{1'b0, 32'h0,         1'b0, 1'b1, 32'h0000_1000, 1'b0, 3'b011, 1'b1, 32'h0000_1000, 32'h0000_0028},
        '{1'b1, 32'h8000_0184, 1'b1, 1'b0, 32'h0,          1'b0, 3'b111, 1'b1, 32'h8000_0180, 32'h8000_0030}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ex_ovf, ex_in_slot, id_bad_op, id_in_slot;
    logic [31:0] ex_pc, id_pc;
    logic        kill_if, kill_id, kill_ex, redirect;
    logic [31:0] redirect_pc, cp0_rdata;
    logic [4:0]  cp0_rd;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    precise_trap_unit i_precise_trap_unit (
        .clk(clk), .rst_n(rst_n),
        .ex_ovf(ex_ovf), .ex_pc(ex_pc), .ex_in_slot(ex_in_slot),
        .id_bad_op(id_bad_op), .id_pc(id_pc), .id_in_slot(id_in_slot),
        .kill_if(kill_if), .kill_id(kill_id), .kill_ex(kill_ex),
        .redirect(redirect), .redirect_pc(redirect_pc),
        .cp0_rd(cp0_rd), .cp0_rdata(cp0_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        ex_ovf = 0; ex_in_slot = 0; ex_pc = '0;
        id_bad_op = 0; id_in_slot = 0; id_pc = '0;
    endtask

    // Read EPC at an even index and cause at an odd index, mid-cycle.
    task automatic read_both(input string req, input logic [31:0] epc, input logic [31:0] cause);
        cp0_rd = 5'd14; #1; check({req, " R8 even"}, cp0_rdata, epc);
        cp0_rd = 5'd13; #1; check({req, " R8 odd"}, cp0_rdata, cause);
    endtask

    initial begin
        rst_n = 0; cp0_rd = 0; quiet();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #2;
        read_both("R1 reset", 32'h0, 32'h0);

        // Table walk: report at a falling edge, kills sampled same cycle,
        // registers read after the next rising edge.
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            ex_ovf = VECS[v].exr; ex_pc = VECS[v].expc; ex_in_slot = VECS[v].exs;
            id_bad_op = VECS[v].idr; id_pc = VECS[v].idpc; id_in_slot = VECS[v].ids;
            #2;
            check("R4/R5 kills", {29'd0, kill_ex, kill_id, kill_if}, {29'd0, VECS[v].kill});
            check("R2/R3 redirect", {31'd0, redirect}, {31'd0, VECS[v].redir});
            if (VECS[v].redir)
                check("R3 target", redirect_pc, 32'h8000_0180);
            @(negedge clk);
            quiet();
            #1;
            read_both("R6 R7 R9 stored", VECS[v].epc, VECS[v].cause);
        end

        // R2: several quiet cycles leave the registers alone and assert nothing.
        repeat (3) @(negedge clk);
        #2;
        check("R2 quiet kill", {28'd0, kill_ex, kill_id, kill_if, redirect}, 32'd0);
        read_both("R2 hold", 32'h8000_0180, 32'h8000_0030);

        // R8: index 0 and index 31 boundaries.
        cp0_rd = 5'd0;  #1; check("R8 rd0", cp0_rdata, 32'h8000_0180);
        cp0_rd = 5'd31; #1; check("R8 rd31", cp0_rdata, 32'h8000_0030);

        // R1: a reset in mid-run clears both registers.
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        #1;
        read_both("R1 mid reset", 32'h0, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule